// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a small byte-wide register file that gathers miscellaneous system controls behind one synchronous bus. A host selects a register with address bits 27:16 and reads or writes a byte with a read or write strobe. The file holds a configuration byte, two auxiliary bytes, a diagnostic byte, a modem-control byte and a system-control byte. A dummy power-management location absorbs writes and always reads back zero.

A power-failing input feeds a pending flag in the second auxiliary register. When the configuration byte enables it, that flag raises an interrupt. Software clears the flag by writing a one to a clear bit. Writing the halt bit of that register requests a shutdown, and writing bit 0 of the system-control byte requests a system reset. Each request leaves the block as a one-cycle pulse. There are two resets. A soft reset clears most of the file but keeps the diagnostic and system-control bytes, so software can tell after a reset that one occurred. A power-on reset clears everything.

Top module: `misc_ctrl_regs`

## Requirements
- R1: A register is selected by addr[27:16] alone: 0x180 config, 0x190 aux1, 0x191 aux2, 0x1A0 diagnostic, 0x1B0 modem control, 0x1F0 system control, 0xA00 power management. Bits 15:0 are ignored. Unmapped selects read 0x00 and ignore writes, and rdata is 0x00 whenever rd_en is low.
- R2: Config, aux1, diagnostic and modem control are plain 8-bit read/write registers. rdata shows the stored byte in the same cycle rd_en is high.
- R3: Writes to the power-management select change no register, and reads from it return 0x00.
- R4: On the clock edge after pwr_failing changes level, the pending flag (aux2 bit 2) is loaded with pwr_failing AND config bit 3. While pwr_failing holds its level, the flag changes only by a clear write or a reset, so enabling config bit 3 later does not set it.
- R5: irq is high exactly when the pending flag and config bit 3 are both 1. It follows a config write on the next edge, without changing the flag.
- R6: An aux2 write stores wdata[0] as the halt bit (aux2 bit 0). aux2 reads as {5'b0, pending, 1'b0, halt}. If wdata[1] is 1, the pending flag is cleared. Bits 7:2 of the write data are otherwise ignored.
- R7: When a pwr_failing change and an aux2 clear write fall on the same edge, the change wins and the flag takes pwr_failing AND config bit 3.
- R8: An aux2 write with wdata[0]=1 makes shutdown_req high for exactly the one cycle after the write edge.
- R9: A system-control write with wdata[0]=1 loads that register with 0x02 and makes reset_req high for exactly the one cycle after the write edge. A write with wdata[0]=0 leaves the register unchanged and gives no pulse.
- R10: Soft reset (rst) clears config, aux1, aux2 (halt and pending), modem control and both request pulses. It keeps the diagnostic and system-control bytes.
- R11: Power-on reset (por) clears every register, including diagnostic and system control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset, clears everything |
| rst | input | 1 | Synchronous active-high soft reset, selective clear |
| addr | input | 28 | Byte address; bits 27:16 select the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, zero when rd_en is low |
| pwr_failing | input | 1 | Power-failing indication from the supply monitor |
| irq | output | 1 | Power-fail interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The pending flag has two sources that can act on the same edge: the hardware, through a level change on pwr_failing, and software, through an aux2 write with the clear bit set. The bench drives both in one cycle, raising pwr_failing while writing 0x02 to aux2 with the interrupt enabled. It then reads aux2 back and samples irq to confirm that the hardware change won (aux2 = 0x04, irq high). A second pairing, a soft reset against the system-control byte, is judged by reading that byte back after the reset.

// File: rtl/misc_ctrl_pkg.sv
package misc_ctrl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 28;
    localparam int SEL_HI = 27;
    localparam int SEL_LO = 16;
    localparam int SEL_W  = SEL_HI - SEL_LO + 1;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam sel_t OFS_CFG   = 12'h180;
    localparam sel_t OFS_AUX1  = 12'h190;
    localparam sel_t OFS_AUX2  = 12'h191;
    localparam sel_t OFS_DIAG  = 12'h1A0;
    localparam sel_t OFS_MCTRL = 12'h1B0;
    localparam sel_t OFS_SYS   = 12'h1F0;
    localparam sel_t OFS_PWR   = 12'hA00;

    // config bit that enables the power-fail interrupt
    localparam int PF_EN_BIT = 3;
    // value loaded into system control when a reset is requested
    localparam byte_t SYS_RESET_MARK = 8'h02;

    typedef enum logic [2:0] {
        RS_NONE  = 3'd0,
        RS_CFG   = 3'd1,
        RS_AUX1  = 3'd2,
        RS_AUX2  = 3'd3,
        RS_DIAG  = 3'd4,
        RS_MCTRL = 3'd5,
        RS_SYS   = 3'd6,
        RS_PWR   = 3'd7
    } regsel_e;

    localparam int NUM_SEL = 8;

    typedef struct packed {
        logic pend;   // power-fail pending, hardware set
        logic halt;   // shutdown trigger, software written
    } aux2_t;

    function automatic regsel_e decode_sel(input sel_t s);
        case (s)
            OFS_CFG:   return RS_CFG;
            OFS_AUX1:  return RS_AUX1;
            OFS_AUX2:  return RS_AUX2;
            OFS_DIAG:  return RS_DIAG;
            OFS_MCTRL: return RS_MCTRL;
            OFS_SYS:   return RS_SYS;
            OFS_PWR:   return RS_PWR;
            default:   return RS_NONE;
        endcase
    endfunction

    function automatic byte_t aux2_view(input aux2_t a);
        return {5'b0, a.pend, 1'b0, a.halt};
    endfunction
endpackage

// File: rtl/misc_ctrl_decode.sv
module misc_ctrl_decode
    import misc_ctrl_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    output regsel_e            sel,
    output logic [NUM_SEL-1:0] wr_hit
);
    assign sel = decode_sel(addr[SEL_HI:SEL_LO]);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_hit
        assign wr_hit[i] = wr_en && (sel == regsel_e'(i));
    end
endmodule

// File: rtl/misc_ctrl_byte_reg.sv
module misc_ctrl_byte_reg #(
    parameter int W        = 8,
    parameter bit SOFT_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         por,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic clr;

    if (SOFT_CLR) begin : g_soft
        assign clr = por | rst;
    end else begin : g_hard
        assign clr = por;
    end

    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/misc_ctrl_pwrfail.sv
module misc_ctrl_pwrfail
    import misc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       pwr_failing,
    input  logic       pf_en,
    input  logic       wr,
    input  logic [1:0] wbits,
    output aux2_t      state,
    output logic       irq,
    output logic       shutdown_req
);
    logic fail_d;
    logic fail_chg;

    assign fail_chg = fail_d != pwr_failing;

    always_ff @(posedge clk) begin
        if (por || rst) begin
            fail_d       <= 1'b0;
            state        <= '0;
            shutdown_req <= 1'b0;
        end else begin
            fail_d       <= pwr_failing;
            shutdown_req <= wr && wbits[0];
            if (wr)
                state.halt <= wbits[0];
            // a level change on the input outranks a software clear
            if (fail_chg)
                state.pend <= pwr_failing & pf_en;
            else if (wr && wbits[1])
                state.pend <= 1'b0;
        end
    end

    assign irq = state.pend & pf_en;
endmodule

// File: rtl/misc_ctrl_sysctl.sv
module misc_ctrl_sysctl
    import misc_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  por,
    input  logic  rst,
    input  logic  wr,
    input  logic  trig,
    output byte_t q,
    output logic  reset_req
);
    always_ff @(posedge clk) begin
        if (por)
            q <= '0;
        else if (wr && trig)
            q <= SYS_RESET_MARK;
    end

    always_ff @(posedge clk) begin
        if (por || rst)
            reset_req <= 1'b0;
        else
            reset_req <= wr && trig;
    end
endmodule

// File: rtl/misc_ctrl_regs.sv
module misc_ctrl_regs
    import misc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pwr_failing,
    output logic              irq,
    output logic              shutdown_req,
    output logic              reset_req
);
    regsel_e            sel;
    logic [NUM_SEL-1:0] wr_hit;
    byte_t              cfg_q, aux1_q, diag_q, mctrl_q, sys_q;
    aux2_t              aux2_q;

    misc_ctrl_decode u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .sel    (sel),
        .wr_hit (wr_hit)
    );

    misc_ctrl_byte_reg #(.W(DATA_W), .SOFT_CLR(1'b1)) u_cfg (
        .clk(clk), .por(por), .rst(rst),
        .we(wr_hit[RS_CFG]), .d(wdata), .q(cfg_q)
    );

    misc_ctrl_byte_reg #(.W(DATA_W), .SOFT_CLR(1'b1)) u_aux1 (
        .clk(clk), .por(por), .rst(rst),
        .we(wr_hit[RS_AUX1]), .d(wdata), .q(aux1_q)
    );

    misc_ctrl_byte_reg #(.W(DATA_W), .SOFT_CLR(1'b0)) u_diag (
        .clk(clk), .por(por), .rst(rst),
        .we(wr_hit[RS_DIAG]), .d(wdata), .q(diag_q)
    );

    misc_ctrl_byte_reg #(.W(DATA_W), .SOFT_CLR(1'b1)) u_mctrl (
        .clk(clk), .por(por), .rst(rst),
        .we(wr_hit[RS_MCTRL]), .d(wdata), .q(mctrl_q)
    );

    misc_ctrl_pwrfail u_pf (
        .clk          (clk),
        .por          (por),
        .rst          (rst),
        .pwr_failing  (pwr_failing),
        .pf_en        (cfg_q[PF_EN_BIT]),
        .wr           (wr_hit[RS_AUX2]),
        .wbits        (wdata[1:0]),
        .state        (aux2_q),
        .irq          (irq),
        .shutdown_req (shutdown_req)
    );

    misc_ctrl_sysctl u_sys (
        .clk       (clk),
        .por       (por),
        .rst       (rst),
        .wr        (wr_hit[RS_SYS]),
        .trig      (wdata[0]),
        .q         (sys_q),
        .reset_req (reset_req)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                RS_CFG:   rdata = cfg_q;
                RS_AUX1:  rdata = aux1_q;
                RS_AUX2:  rdata = aux2_view(aux2_q);
                RS_DIAG:  rdata = diag_q;
                RS_MCTRL: rdata = mctrl_q;
                RS_SYS:   rdata = sys_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/misc_ctrl_regs_chk.sv
module misc_ctrl_regs_chk
    import misc_ctrl_pkg::*;
(
    input logic              clk,
    input logic              por,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              shutdown_req,
    input logic              reset_req,
    input byte_t             cfg_q,
    input byte_t             sys_q,
    input aux2_t             aux2_q
);
    logic shut_hit, sys_hit;

    assign shut_hit = wr_en && (addr[SEL_HI:SEL_LO] == OFS_AUX2) && wdata[0];
    assign sys_hit  = wr_en && (addr[SEL_HI:SEL_LO] == OFS_SYS) && wdata[0];

    // R8
    shut_follows_chk: assert property (@(posedge clk) disable iff (por || rst)
        shut_hit |=> shutdown_req);

    // R8
    shut_cause_chk: assert property (@(posedge clk) disable iff (por || rst)
        shutdown_req |-> $past(shut_hit));

    // R9
    rst_follows_chk: assert property (@(posedge clk) disable iff (por || rst)
        sys_hit |=> (reset_req && sys_q == SYS_RESET_MARK));

    // R9
    rst_cause_chk: assert property (@(posedge clk) disable iff (por || rst)
        reset_req |-> $past(sys_hit));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (por || rst)
        irq |-> (cfg_q[PF_EN_BIT] && aux2_q.pend));

    // R10
    sys_keep_chk: assert property (@(posedge clk) disable iff (por)
        (rst && !sys_hit) |=> $stable(sys_q));
endmodule

bind misc_ctrl_regs misc_ctrl_regs_chk u_chk (
    .clk          (clk),
    .por          (por),
    .rst          (rst),
    .addr         (addr),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .irq          (irq),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .cfg_q        (cfg_q),
    .sys_q        (sys_q),
    .aux2_q       (aux2_q)
);

// File: tb/misc_ctrl_regs_test.sv
module misc_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b1;
    logic [27:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        pwr_failing = 1'b0;
    logic        irq, shutdown_req, reset_req;

    int total = 0;
    int bad   = 0;

    misc_ctrl_regs uut (
        .clk(clk), .por(por), .rst(rst), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .pwr_failing(pwr_failing), .irq(irq),
        .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    always #5 clk = ~clk;

    localparam logic [11:0] A_CFG = 12'h180, A_AUX1 = 12'h190, A_AUX2 = 12'h191,
                            A_DIAG = 12'h1A0, A_MCTRL = 12'h1B0, A_SYS = 12'h1F0,
                            A_PWR = 12'hA00, A_NONE = 12'h120;

    function automatic logic [27:0] ad(input logic [11:0] o);
        return {o, 16'h0000};
    endfunction

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [27:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [27:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic set_pf(input logic v);
        @(negedge clk);
        pwr_failing = v;
        @(negedge clk);
    endtask

    task automatic do_soft_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_por();
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(ad(A_CFG), v);  chk("R11 cfg", v, 8'h00);
        rd(ad(A_AUX2), v); chk("R11 aux2", v, 8'h00);
        rd(ad(A_SYS), v);  chk("R11 sys", v, 8'h00);
        rd(ad(A_DIAG), v); chk("R11 diag", v, 8'h00);
        chk("R11 irq", {7'b0, irq}, 8'h00);
        chk("R11 pulses", {6'b0, shutdown_req, reset_req}, 8'h00);
    endtask

    task automatic t_plain();
        logic [7:0] v;
        wr(ad(A_CFG), 8'hA5);
        wr(ad(A_AUX1) | 28'h1234, 8'h3C);
        wr(ad(A_DIAG), 8'h5A);
        wr(ad(A_MCTRL), 8'hC3);
        rd(ad(A_CFG), v);  chk("R2 cfg", v, 8'hA5);
        rd(ad(A_AUX1), v); chk("R1 low bits ignored aux1", v, 8'h3C);
        rd(ad(A_DIAG) | 28'h00FF, v); chk("R2 diag", v, 8'h5A);
        rd(ad(A_MCTRL), v); chk("R2 mctrl", v, 8'hC3);
        @(negedge clk); addr = ad(A_CFG); #1;
        chk("R1 rdata idle zero", rdata, 8'h00);
    endtask

    task automatic t_pwr_unmapped();
        logic [7:0] v;
        wr(ad(A_PWR), 8'hFF);
        rd(ad(A_PWR), v);  chk("R3 pwr reads zero", v, 8'h00);
        wr(ad(A_NONE), 8'h77);
        rd(ad(A_NONE), v); chk("R1 unmapped reads zero", v, 8'h00);
        rd(ad(A_CFG), v);  chk("R3 cfg untouched", v, 8'hA5);
        rd(ad(A_AUX1), v); chk("R1 aux1 untouched", v, 8'h3C);
        rd(ad(A_AUX2), v); chk("R3 aux2 untouched", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(ad(A_CFG), 8'h00);
        set_pf(1'b1);
        rd(ad(A_AUX2), v); chk("R4 gated off", v, 8'h00);
        wr(ad(A_CFG), 8'h08);
        rd(ad(A_AUX2), v); chk("R4 no set without change", v, 8'h00);
        chk("R5 irq low", {7'b0, irq}, 8'h00);
        set_pf(1'b0);
        set_pf(1'b1);
        chk("R5 irq on fail", {7'b0, irq}, 8'h01);
        rd(ad(A_AUX2), v); chk("R4 pending set", v, 8'h04);
        wr(ad(A_CFG), 8'h00);
        chk("R5 irq masked", {7'b0, irq}, 8'h00);
        rd(ad(A_AUX2), v); chk("R5 pending kept", v, 8'h04);
        wr(ad(A_CFG), 8'h08);
        chk("R5 irq unmasked", {7'b0, irq}, 8'h01);
        wr(ad(A_AUX2), 8'h02);
        chk("R6 clear drops irq", {7'b0, irq}, 8'h00);
        rd(ad(A_AUX2), v); chk("R6 cleared", v, 8'h00);
        chk("R8 no shutdown on clear", {7'b0, shutdown_req}, 8'h00);
        set_pf(1'b0);
        set_pf(1'b1);
        chk("R4 set again", {7'b0, irq}, 8'h01);
        set_pf(1'b0);
        chk("R4 fall clears", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        // cfg enable is 0x08 from the previous scenario, input is low
        @(negedge clk);
        addr = ad(A_AUX2); wdata = 8'h02; wr_en = 1'b1; pwr_failing = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 hardware wins irq", {7'b0, irq}, 8'h01);
        rd(ad(A_AUX2), v); chk("R7 hardware wins aux2", v, 8'h04);
        set_pf(1'b0);
    endtask

    task automatic t_shutdown();
        logic [7:0] v;
        wr(ad(A_AUX2), 8'hFD);
        chk("R8 pulse high", {7'b0, shutdown_req}, 8'h01);
        @(negedge clk);
        chk("R8 pulse one cycle", {7'b0, shutdown_req}, 8'h00);
        rd(ad(A_AUX2), v); chk("R6 only bit0 kept", v, 8'h01);
        wr(ad(A_AUX2), 8'h00);
        chk("R8 no pulse", {7'b0, shutdown_req}, 8'h00);
        rd(ad(A_AUX2), v); chk("R6 halt cleared", v, 8'h00);
        wr(ad(A_AUX2), 8'h03);
        chk("R8 pulse with clear", {7'b0, shutdown_req}, 8'h01);
        rd(ad(A_AUX2), v); chk("R6 bit1 not stored", v, 8'h01);
    endtask

    task automatic t_sysctl();
        logic [7:0] v;
        wr(ad(A_SYS), 8'hFE);
        chk("R9 no pulse bit0 clear", {7'b0, reset_req}, 8'h00);
        rd(ad(A_SYS), v); chk("R9 unchanged", v, 8'h00);
        wr(ad(A_SYS), 8'h01);
        chk("R9 pulse", {7'b0, reset_req}, 8'h01);
        @(negedge clk);
        chk("R9 pulse one cycle", {7'b0, reset_req}, 8'h00);
        rd(ad(A_SYS), v); chk("R9 mark", v, 8'h02);
        wr(ad(A_SYS), 8'h00);
        rd(ad(A_SYS), v); chk("R9 kept on bit0 clear", v, 8'h02);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        wr(ad(A_CFG), 8'h08);
        wr(ad(A_MCTRL), 8'h99);
        wr(ad(A_DIAG), 8'h66);
        do_soft_reset();
        rd(ad(A_CFG), v);   chk("R10 cfg cleared", v, 8'h00);
        rd(ad(A_AUX1), v);  chk("R10 aux1 cleared", v, 8'h00);
        rd(ad(A_AUX2), v);  chk("R10 aux2 cleared", v, 8'h00);
        rd(ad(A_MCTRL), v); chk("R10 mctrl cleared", v, 8'h00);
        rd(ad(A_DIAG), v);  chk("R10 diag kept", v, 8'h66);
        rd(ad(A_SYS), v);   chk("R10 sys kept", v, 8'h02);
        do_por();
        rd(ad(A_DIAG), v);  chk("R11 diag cleared", v, 8'h00);
        rd(ad(A_SYS), v);   chk("R11 sys cleared", v, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por = 1'b0; rst = 1'b0;
        t_reset();
        t_plain();
        t_pwr_unmapped();
        t_irq();
        t_same_cycle();
        t_shutdown();
        t_sysctl();
        t_soft_reset();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule